// File: doc/BRIEF.md
# Die Status Query Sequencer

This block is the host-side controller that fetches the status of one die on a multi-die hashing chip. A caller pulses a start input with a die index and the number of cores it expects on that die. The sequencer works out how long the link transfer must be, builds a four-byte query command and hands both to a separate framed-transaction engine through a valid/ready request. The engine returns the received bytes one at a time, then ends the transfer with a completion strobe and a set of error flags. The engine owns the serial link and the CRC arithmetic.

The sequencer decides what to do after each response. A transfer whose only problem is a transmit-side CRC failure is sent again, within a fixed attempt budget. A response with other errors may still carry a readable header. If the header shows the right chip revision but a different core count, the sequencer recomputes the transfer length from that count and runs the attempt loop once more. On completion it raises a one-cycle done pulse with a pass flag and a cause code. On success it also presents the core count, a 64-bit PLL state word and a per-core pair of status bits (wants work, has a report).

Top module: `dsq_die_query`

## Requirements
- R1: In the request phase, `req_cmd` carries byte 0x80 in bits 31:24, the die index in bits 23:16 and zero in bits 15:0. `req_valid`, `req_cmd` and `req_len` stay stable until `req_ready` is seen.
- R2: The first request of a query has `req_len` = 24 + ceil(expected_cores / 4) bytes.
- R3: The transmit-CRC flag is `rsp_err` bit 0. When it is the only flag set, the same request is issued again, up to 3 attempts in one loop. If it is still the only flag after the third attempt of the first loop, the query ends with cause 2 (transmit CRC).
- R4: When `rsp_err` bit 3 (engine abort) is set, the query ends at once with cause 1 and no further request is issued.
- R5: The revision is response bytes 6 and 7, with byte 6 as the high byte. If it differs from REVISION (default 0xA102) after a non-retried response, the query ends with cause 3. In the first loop this check comes before the core-count check.
- R6: The core count is response bytes 4 and 5, with byte 4 as the high byte. If the response had errors, the revision is correct and the count differs from the expected count, exactly one more attempt loop runs with `req_len` = 24 + ceil(count / 4).
- R7: The query ends with cause 4 (communication failure) in these cases: flags remain after the resized loop; a sole transmit-CRC flag persists after three attempts of the resized loop; or errors remain with a correct revision and a count equal to the expected count.
- R8: A response with no flags, the correct revision and a count of at most MAX_CORES gives `ok`=1 and cause 0. `cores` then holds the count and `pll_state` holds bytes 8..15, with byte 8 in bits 63:56.
- R9: The status byte for cores 4k..4k+3 is response byte 16+k. Within that byte, core 4k+j takes its want-work bit from bit 7-2j and its has-report bit from bit 6-2j. Cores at or above the count read zero.
- R10: A clean response with the correct revision and a count above MAX_CORES gives `ok`=0, cause 5, `cores`=MAX_CORES, and the status bits of the first MAX_CORES cores.
- R11: `done` is a single-cycle pulse, raised once per accepted start. A start that arrives while a query is in progress is ignored.
- R12: When a query ends with cause 1 to 4, `cores`, `pll_state`, `want_work` and `have_report` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| die_idx | input | 8 | Die to query |
| exp_cores | input | 16 | Expected core count of that die |
| req_valid | output | 1 | Transfer request to the engine |
| req_ready | input | 1 | Engine accepts the request |
| req_cmd | output | 32 | Four-byte query command, first byte in the top bits |
| req_len | output | LEN_W | Total transfer length in bytes |
| rsp_bvalid | input | 1 | A received byte is present |
| rsp_bdata | input | 8 | Received byte, in order from byte 0 |
| rsp_done | input | 1 | Transfer complete; rsp_err is valid |
| rsp_err | input | 4 | Flags: 0 tx CRC, 1 rx CRC, 2 bad frame, 3 abort |
| done | output | 1 | Query finished (one cycle) |
| ok | output | 1 | Query succeeded |
| cause | output | 3 | 0 none, 1 abort, 2 tx CRC, 3 revision, 4 link, 5 core limit |
| cores | output | 16 | Reported core count (clamped) |
| pll_state | output | 64 | PLL state word |
| want_work | output | MAX_CORES | Per-core want-work bit |
| have_report | output | MAX_CORES | Per-core has-report bit |

## Verification
The bench targets these corner cases:

- A core count that differs from the expectation but rounds to the same transfer length must succeed with no retry. A design that compares counts instead of error flags would resize anyway.
- A count mismatch together with a transmit-CRC flag must still resize, because that flag is not the only one set.
- A resized loop that keeps failing on transmit CRC must report a link failure, not a transmit-CRC failure.
- A last status byte that is only partly used must have its upper-core bits masked. Counts above the bitmap width must be clamped.
- A start pulse sent during a retry must not change the die in the next command and must not add a second done pulse.

A design that counted attempts wrongly would show the wrong number of requests. One that skipped the revision check on an errored response would resize instead of failing.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

   localparam int          CNT_W        = 16;
   localparam int          ERR_W        = 4;
   localparam int          ERR_TXCRC    = 0;
   localparam int          ERR_RXCRC    = 1;
   localparam int          ERR_FRAME    = 2;
   localparam int          ERR_ABORT    = 3;
   localparam logic [7:0]  QUERY_OPCODE = 8'h80;
   localparam int          FIXED_BYTES  = 24;
   localparam int          CNT_OFFSET   = 4;
   localparam int          REV_OFFSET   = 6;
   localparam int          PLL_OFFSET   = 8;
   localparam int          BMP_OFFSET   = 16;

   typedef enum logic [2:0] {
      CAUSE_NONE   = 3'd0,
      CAUSE_ABORT  = 3'd1,
      CAUSE_TXCRC  = 3'd2,
      CAUSE_BADREV = 3'd3,
      CAUSE_COMM   = 3'd4,
      CAUSE_LIMIT  = 3'd5
   } dsq_cause_e;

   // transfer length for a given core count: fixed part plus one byte per four cores
   function automatic logic [16:0] xfer_len(input logic [CNT_W-1:0] n);
      logic [16:0] q;
      q = ({1'b0, n} + 17'd3) >> 2;
      return q + 17'(FIXED_BYTES);
   endfunction

endpackage

// File: rtl/dsq_rx_capture.sv
module dsq_rx_capture
   import dsq_pkg::*;
#(
   parameter int MAX_CORES     = 48,
   parameter bit PLL_BYTE0_MSB = 1'b1,
   localparam int BMP_BYTES    = (MAX_CORES + 3) / 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   bvalid,
   input  logic [7:0]             bdata,
   output logic [CNT_W-1:0]       count_o,
   output logic [15:0]            rev_o,
   output logic [63:0]            pll_o,
   output logic [BMP_BYTES*8-1:0] bmp_o
);

   logic [15:0] idx_q;
   logic        take;

   assign take = bvalid && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clear) begin
         idx_q <= '0;
      end else if (bvalid && idx_q != 16'hFFFF) begin
         idx_q <= idx_q + 16'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o <= '0;
         rev_o   <= '0;
      end else if (clear) begin
         count_o <= '0;
         rev_o   <= '0;
      end else if (take) begin
         case (idx_q)
            16'(CNT_OFFSET):     count_o[15:8] <= bdata;
            16'(CNT_OFFSET + 1): count_o[7:0]  <= bdata;
            16'(REV_OFFSET):     rev_o[15:8]   <= bdata;
            16'(REV_OFFSET + 1): rev_o[7:0]    <= bdata;
            default: ;
         endcase
      end
   end

   for (genvar b = 0; b < 8; b++) begin : g_pll
      localparam int POS = PLL_BYTE0_MSB ? (7 - b) : b;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pll_o[POS*8 +: 8] <= '0;
         end else if (clear) begin
            pll_o[POS*8 +: 8] <= '0;
         end else if (take && idx_q == 16'(PLL_OFFSET + b)) begin
            pll_o[POS*8 +: 8] <= bdata;
         end
      end
   end

   for (genvar k = 0; k < BMP_BYTES; k++) begin : g_bmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bmp_o[k*8 +: 8] <= '0;
         end else if (clear) begin
            bmp_o[k*8 +: 8] <= '0;
         end else if (take && idx_q == 16'(BMP_OFFSET + k)) begin
            bmp_o[k*8 +: 8] <= bdata;
         end
      end
   end

   // the byte index restarts with every accepted request
   assert_idx_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> idx_q == 16'd0);

endmodule

// File: rtl/dsq_unpack.sv
module dsq_unpack
   import dsq_pkg::*;
#(
   parameter int MAX_CORES  = 48,
   localparam int BMP_BYTES = (MAX_CORES + 3) / 4
) (
   input  logic [BMP_BYTES*8-1:0] bmp,
   input  logic [CNT_W-1:0]       count,
   output logic [MAX_CORES-1:0]   want,
   output logic [MAX_CORES-1:0]   have
);

   for (genvar i = 0; i < MAX_CORES; i++) begin : g_core
      localparam int BYTE_I = i / 4;
      localparam int SLOT   = i % 4;
      localparam int WBIT   = BYTE_I * 8 + 7 - 2 * SLOT;
      logic live;
      assign live    = 16'(i) < count;
      assign want[i] = live && bmp[WBIT];
      assign have[i] = live && bmp[WBIT-1];
   end

endmodule

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
   import dsq_pkg::*;
#(
   parameter int          MAX_CORES = 48,
   parameter int          MAX_TRIES = 3,
   parameter int          LEN_W     = 16,
   parameter logic [15:0] REVISION  = 16'hA102,
   localparam int         TRY_W     = $clog2(MAX_TRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       die_idx,
   input  logic [CNT_W-1:0] exp_cores,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [31:0]      req_cmd,
   output logic [LEN_W-1:0] req_len,
   input  logic             rsp_done,
   input  logic [ERR_W-1:0] rsp_err,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [15:0]      rx_rev,
   output logic             fin,
   output dsq_cause_e       fin_cause
);

   typedef enum logic [1:0] {S_IDLE, S_REQ, S_RX} st_e;

   st_e              state_q, state_d;
   logic [7:0]       die_q;
   logic [CNT_W-1:0] hint_q;
   logic [LEN_W-1:0] len_q;
   logic [TRY_W-1:0] tries_q;
   logic             resized_q;
   logic             go_retry, go_resize;
   logic             err_any, err_sole_tx, err_abort;
   logic             rev_ok, count_mism, over;

   assign err_any     = |rsp_err;
   assign err_abort   = rsp_err[ERR_ABORT];
   assign err_sole_tx = rsp_err == ERR_W'(1 << ERR_TXCRC);
   assign rev_ok      = rx_rev == REVISION;
   assign count_mism  = rx_count != hint_q;
   assign over        = rx_count > CNT_W'(MAX_CORES);

   always_comb begin
      state_d   = state_q;
      fin       = 1'b0;
      fin_cause = CAUSE_NONE;
      go_retry  = 1'b0;
      go_resize = 1'b0;
      case (state_q)
         S_IDLE: if (start) state_d = S_REQ;
         S_REQ:  if (req_ready) state_d = S_RX;
         S_RX: begin
            if (rsp_done) begin
               if (err_abort) begin
                  fin = 1'b1; fin_cause = CAUSE_ABORT;
               end else if (err_sole_tx && tries_q < TRY_W'(MAX_TRIES - 1)) begin
                  go_retry = 1'b1;
               end else if (err_sole_tx) begin
                  fin = 1'b1; fin_cause = resized_q ? CAUSE_COMM : CAUSE_TXCRC;
               end else if (err_any) begin
                  if (resized_q) begin
                     fin = 1'b1; fin_cause = CAUSE_COMM;
                  end else if (!rev_ok) begin
                     fin = 1'b1; fin_cause = CAUSE_BADREV;
                  end else if (count_mism) begin
                     go_resize = 1'b1;
                  end else begin
                     fin = 1'b1; fin_cause = CAUSE_COMM;
                  end
               end else if (!rev_ok) begin
                  fin = 1'b1; fin_cause = CAUSE_BADREV;
               end else if (over) begin
                  fin = 1'b1; fin_cause = CAUSE_LIMIT;
               end else begin
                  fin = 1'b1; fin_cause = CAUSE_NONE;
               end
               state_d = fin ? S_IDLE : S_REQ;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         die_q     <= '0;
         hint_q    <= '0;
         len_q     <= '0;
         tries_q   <= '0;
         resized_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == S_IDLE && start) begin
            die_q     <= die_idx;
            hint_q    <= exp_cores;
            len_q     <= LEN_W'(xfer_len(exp_cores));
            tries_q   <= '0;
            resized_q <= 1'b0;
         end else if (go_retry) begin
            tries_q <= tries_q + TRY_W'(1);
         end else if (go_resize) begin
            len_q     <= LEN_W'(xfer_len(rx_count));
            tries_q   <= '0;
            resized_q <= 1'b1;
         end
      end
   end

   assign req_valid = state_q == S_REQ;
   assign req_cmd   = {QUERY_OPCODE, die_q, 16'h0000};
   assign req_len   = len_q;

   assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_cmd) && $stable(req_len));

   assert_try_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q < TRY_W'(MAX_TRIES));

   assert_txcrc_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fin && fin_cause == CAUSE_TXCRC |-> tries_q == TRY_W'(MAX_TRIES - 1) && !resized_q);

   assert_resize_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resized_q && state_q != S_IDLE |=> resized_q || state_q == S_IDLE);

   assert_abort_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == S_RX && rsp_done && rsp_err[ERR_ABORT] |=> state_q == S_IDLE);

endmodule

// File: rtl/dsq_die_query.sv
module dsq_die_query
   import dsq_pkg::*;
#(
   parameter int          MAX_CORES     = 48,
   parameter int          MAX_TRIES     = 3,
   parameter int          LEN_W         = 16,
   parameter logic [15:0] REVISION      = 16'hA102,
   parameter bit          PLL_BYTE0_MSB = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [7:0]           die_idx,
   input  logic [15:0]          exp_cores,
   output logic                 req_valid,
   input  logic                 req_ready,
   output logic [31:0]          req_cmd,
   output logic [LEN_W-1:0]     req_len,
   input  logic                 rsp_bvalid,
   input  logic [7:0]           rsp_bdata,
   input  logic                 rsp_done,
   input  logic [3:0]           rsp_err,
   output logic                 done,
   output logic                 ok,
   output logic [2:0]           cause,
   output logic [15:0]          cores,
   output logic [63:0]          pll_state,
   output logic [MAX_CORES-1:0] want_work,
   output logic [MAX_CORES-1:0] have_report
);

   localparam int BMP_BYTES = (MAX_CORES + 3) / 4;

   if (MAX_CORES < 1 || MAX_CORES > 4096) begin : g_bad_cores
      $error("dsq_die_query: MAX_CORES out of range");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("dsq_die_query: MAX_TRIES must be at least 1");
   end
   if (LEN_W < 15) begin : g_bad_len
      $error("dsq_die_query: LEN_W too narrow for the longest transfer");
   end

   logic                   cap_clear;
   logic [CNT_W-1:0]       rx_count, clamp_count;
   logic [15:0]            rx_rev;
   logic [63:0]            rx_pll;
   logic [BMP_BYTES*8-1:0] rx_bmp;
   logic [MAX_CORES-1:0]   un_want, un_have;
   logic                   fin;
   dsq_cause_e             fin_cause;
   logic                   keep_data;

   assign cap_clear   = req_valid && req_ready;
   assign clamp_count = (rx_count > CNT_W'(MAX_CORES)) ? CNT_W'(MAX_CORES) : rx_count;
   assign keep_data   = fin_cause == CAUSE_NONE || fin_cause == CAUSE_LIMIT;

   dsq_ctrl #(
      .MAX_CORES (MAX_CORES),
      .MAX_TRIES (MAX_TRIES),
      .LEN_W     (LEN_W),
      .REVISION  (REVISION)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .die_idx   (die_idx),
      .exp_cores (exp_cores),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_cmd   (req_cmd),
      .req_len   (req_len),
      .rsp_done  (rsp_done),
      .rsp_err   (rsp_err),
      .rx_count  (rx_count),
      .rx_rev    (rx_rev),
      .fin       (fin),
      .fin_cause (fin_cause)
   );

   dsq_rx_capture #(
      .MAX_CORES     (MAX_CORES),
      .PLL_BYTE0_MSB (PLL_BYTE0_MSB)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cap_clear),
      .bvalid  (rsp_bvalid),
      .bdata   (rsp_bdata),
      .count_o (rx_count),
      .rev_o   (rx_rev),
      .pll_o   (rx_pll),
      .bmp_o   (rx_bmp)
   );

   dsq_unpack #(
      .MAX_CORES (MAX_CORES)
   ) u_unpack (
      .bmp   (rx_bmp),
      .count (clamp_count),
      .want  (un_want),
      .have  (un_have)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done        <= 1'b0;
         ok          <= 1'b0;
         cause       <= CAUSE_NONE;
         cores       <= '0;
         pll_state   <= '0;
         want_work   <= '0;
         have_report <= '0;
      end else begin
         done <= fin;
         if (fin) begin
            ok    <= fin_cause == CAUSE_NONE;
            cause <= fin_cause;
            if (keep_data) begin
               cores       <= clamp_count;
               pll_state   <= rx_pll;
               want_work   <= un_want;
               have_report <= un_have;
            end else begin
               cores       <= '0;
               pll_state   <= '0;
               want_work   <= '0;
               have_report <= '0;
            end
         end
      end
   end

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_ok_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done && ok |-> cause == 3'(CAUSE_NONE));

   assert_limit_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done && cause == 3'(CAUSE_LIMIT) |-> cores == 16'(MAX_CORES) && !ok);

   assert_fail_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done && !ok && cause != 3'(CAUSE_LIMIT)
      |-> cores == 16'd0 && pll_state == 64'd0 && want_work == '0 && have_report == '0);

   assert_mask_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(want_work) <= int'(cores) && $countones(have_report) <= int'(cores));

endmodule

// File: tb/tb_dsq_die_query.sv
module tb_dsq_die_query;

   localparam int MAXC  = 48;
   localparam int LEN_W = 16;
   localparam logic [15:0] REV = 16'hA102;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [7:0] die_idx = '0;
   logic [15:0] exp_cores = '0;
   logic req_valid, req_ready = 1'b0;
   logic [31:0] req_cmd;
   logic [LEN_W-1:0] req_len;
   logic rsp_bvalid = 1'b0;
   logic [7:0] rsp_bdata = '0;
   logic rsp_done = 1'b0;
   logic [3:0] rsp_err = '0;
   logic done, ok;
   logic [2:0] cause;
   logic [15:0] cores;
   logic [63:0] pll_state;
   logic [MAXC-1:0] want_work, have_report;

   always #2 clk = ~clk;

   dsq_die_query dut (
      .clk(clk), .rst_n(rst_n), .start(start), .die_idx(die_idx), .exp_cores(exp_cores),
      .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_len(req_len),
      .rsp_bvalid(rsp_bvalid), .rsp_bdata(rsp_bdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
      .done(done), .ok(ok), .cause(cause), .cores(cores), .pll_state(pll_state),
      .want_work(want_work), .have_report(have_report)
   );

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   // chip model
   int          ch_cores;
   logic [15:0] ch_rev;
   logic [63:0] ch_pll;
   logic [7:0]  ch_stat [0:31];
   logic [7:0]  tx_mask, fr_mask;
   int          abort_at;

   task automatic check(input bit cond, input string req, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   function automatic int lenf(input int n);
      return 24 + (n + 3) / 4;
   endfunction

   function automatic logic [3:0] errf(input int a, input int l);
      logic [3:0] e;
      e[0] = (a < 8) ? tx_mask[a] : 1'b0;
      e[1] = l != lenf(ch_cores);
      e[2] = (a < 8) ? fr_mask[a] : 1'b0;
      e[3] = a == abort_at;
      return e;
   endfunction

   function automatic logic [7:0] rbyte(input int i);
      if (i == 4) return 8'(ch_cores >> 8);
      if (i == 5) return 8'(ch_cores);
      if (i == 6) return ch_rev[15:8];
      if (i == 7) return ch_rev[7:0];
      if (i >= 8 && i < 16) return ch_pll[63-8*(i-8) -: 8];
      if (i >= 16 && i < 48) return ch_stat[i-16];
      return 8'h5A;
   endfunction

   // reference of the query procedure, from the requirements
   task automatic model(input int hint, output int cz, output int att, output int last_len);
      int l, t;
      bit rs;
      logic [3:0] e;
      l = lenf(hint); t = 0; rs = 0; att = 0; cz = 0;
      forever begin
         e = errf(att, l); att++; t++; last_len = l;
         if (e[3]) begin cz = 1; return; end
         if (e == 4'b0001 && t < 3) continue;
         if (e == 4'b0001) begin cz = rs ? 4 : 2; return; end
         if (e != 0) begin
            if (rs) begin cz = 4; return; end
            if (ch_rev != REV) begin cz = 3; return; end
            if (ch_cores != hint) begin rs = 1; t = 0; l = lenf(ch_cores); continue; end
            cz = 4; return;
         end
         if (ch_rev != REV) cz = 3;
         else if (ch_cores > MAXC) cz = 5;
         else cz = 0;
         return;
      end
   endtask

   function automatic bit exp_bit(input int i, input bit hv);
      int n;
      n = (ch_cores > MAXC) ? MAXC : ch_cores;
      if (i >= n) return 1'b0;
      return ch_stat[i/4][7 - 2*(i%4) - (hv ? 1 : 0)];
   endfunction

   task automatic query(input logic [7:0] die, input int hint, input bit poke, input string tag);
      int e_cause, e_att, e_last, att, wd, first_len, last_len;
      logic [MAXC-1:0] ew, eh;
      bit fin_seen;
      model(hint, e_cause, e_att, e_last);
      @(negedge clk);
      die_idx = die; exp_cores = 16'(hint); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      att = 0; fin_seen = 0; wd = 0; first_len = -1; last_len = -1;
      while (!fin_seen && wd < 4000) begin
         if (done) begin
            fin_seen = 1;
         end else if (req_valid) begin
            repeat ($urandom_range(0, 2)) begin
               @(negedge clk);
               check(req_valid, "R1", "valid held", req_valid, 1);
            end
            check(req_cmd == {8'h80, die, 16'h0}, "R1", "command", req_cmd, {8'h80, die, 16'h0});
            if (att == 0) first_len = int'(req_len);
            last_len = int'(req_len);
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            for (int b = 0; b < last_len; b++) begin
               if ($urandom_range(0, 7) == 0) @(negedge clk);
               rsp_bvalid = 1'b1; rsp_bdata = rbyte(b);
               if (poke && att == 0 && b == 2) begin
                  start = 1'b1; die_idx = 8'hEE; exp_cores = 16'd7;
               end
               @(negedge clk);
               rsp_bvalid = 1'b0; start = 1'b0;
            end
            rsp_done = 1'b1; rsp_err = errf(att, last_len);
            att++;
            @(negedge clk);
            rsp_done = 1'b0; rsp_err = '0;
         end else begin
            @(negedge clk);
            wd++;
         end
      end
      check(fin_seen, tag, "done seen", fin_seen, 1);
      check(first_len == lenf(hint), "R2", "first length", first_len, lenf(hint));
      check(att == e_att, (e_cause == 2) ? "R3" : "R6", "attempts", att, e_att);
      check(last_len == e_last, "R6", "last length", last_len, e_last);
      check(cause == 3'(e_cause), tag, "cause", cause, e_cause);
      check(ok == (e_cause == 0), "R8", "ok", ok, e_cause == 0);
      if (e_cause == 0 || e_cause == 5) begin
         for (int i = 0; i < MAXC; i++) begin
            ew[i] = exp_bit(i, 0); eh[i] = exp_bit(i, 1);
         end
         check(cores == 16'((ch_cores > MAXC) ? MAXC : ch_cores), (e_cause == 5) ? "R10" : "R8",
               "cores", cores, (ch_cores > MAXC) ? MAXC : ch_cores);
         check(pll_state == ch_pll, "R8", "pll", pll_state, ch_pll);
         check(want_work == ew, "R9", "want", want_work, ew);
         check(have_report == eh, "R9", "have", have_report, eh);
      end else begin
         check(cores == 0 && pll_state == 0 && want_work == 0 && have_report == 0,
               "R12", "cleared", cores, 0);
      end
      @(negedge clk);
      check(!done, "R11", "done pulse width", done, 0);
      repeat (3) begin
         @(negedge clk);
         check(!req_valid && !done, "R11", "idle after done", {req_valid, done}, 0);
      end
   endtask

   task automatic chip(input int c, input logic [15:0] rv, input logic [7:0] tm,
                       input logic [7:0] fm, input int ab);
      ch_cores = c; ch_rev = rv; tx_mask = tm; fr_mask = fm; abort_at = ab;
      ch_pll = {$urandom, $urandom};
      for (int k = 0; k < 32; k++) ch_stat[k] = 8'($urandom);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(!done && !req_valid && !ok && cause == 0 && cores == 0, "R11", "reset state",
            {done, req_valid, ok, cause}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      chip(48, REV, 0, 0, -1);          query(8'd0, 48, 0, "R8");
      chip(45, REV, 0, 0, -1);          query(8'd1, 48, 0, "R9");
      chip(40, REV, 0, 0, -1);          query(8'd2, 48, 0, "R6");
      chip(48, REV, 8'b011, 0, -1);     query(8'd3, 48, 1, "R3");
      chip(48, REV, 8'b111, 0, -1);     query(8'd3, 48, 0, "R3");
      chip(48, 16'hA101, 0, 0, -1);     query(8'd2, 40, 0, "R5");
      chip(48, 16'h1234, 0, 0, -1);     query(8'd1, 48, 0, "R5");
      chip(48, REV, 8'b001, 0, 1);      query(8'd0, 48, 0, "R4");
      chip(44, REV, 8'b1111, 0, -1);    query(8'd3, 40, 0, "R7");
      chip(40, REV, 0, 8'b10, -1);      query(8'd1, 48, 0, "R7");
      chip(48, REV, 0, 8'b1, -1);       query(8'd1, 48, 0, "R7");
      chip(60, REV, 0, 0, -1);          query(8'd2, 60, 0, "R10");
      chip(0, REV, 0, 0, -1);           query(8'd0, 0, 0, "R8");

      for (int r = 0; r < 30; r++) begin
         int c, h;
         c = $urandom_range(0, 60);
         h = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 60) : c;
         chip(c, ($urandom_range(0, 7) == 0) ? 16'hBEEF : REV,
              ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom),
              ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 3)) : 8'h00,
              ($urandom_range(0, 9) == 0) ? $urandom_range(0, 3) : -1);
         query(8'($urandom_range(0, 3)), h, r % 5 == 0, "R8");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule